// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This block carries out word and byte loads and stores against a byte-addressed memory built from two 8-bit banks. The even lane holds the low byte of each 16-bit word and the odd lane holds the high byte. With `BANK_AW` set to 15 each lane is 32K x 8, which gives 64 KB in total. The default is smaller so that the block stays light to elaborate. The bank storage is modelled inside the block. The address arrives already computed.

Each memory access takes two cycles. In the first cycle the request is presented, and at the clock edge that ends it the address register, the store data and the access controls are latched. In the second cycle the latched controls alone drive each lane's chip-, write- and output-enable. The write strobe lasts exactly that one cycle and is withdrawn by the edge that closes it. A left 8-bit shifter moves a byte headed for the odd lane into position. A right 8-bit shifter with sign or zero extension brings an odd-lane byte down to the low byte. While no access is in its second cycle, the same two shifters give logical left, logical right and arithmetic right shifts by 8 of the request operand.

Top module: `lsu_bytelane`

## Requirements
- R1: While reset is active and afterwards until a request arrives, `busy` and `res_valid` are 0 and all six bank enables (active low) are 1.
- R2: A memory request (`req_op` 1=word load, 2=byte load, 3=word store, 4=byte store) presented with `req_valid` while `busy` is 0 is taken at the next rising edge. In the cycle that follows, `busy` is 1 and the bank enables act. After the next edge `busy` is 0 again.
- R3: A request of any kind presented while `busy` is 1 is ignored. It starts no access and changes no memory contents.
- R4: A word access ignores address bit 0 and uses both lanes. A word store write-enables both lanes with byte [7:0] to the even lane and byte [15:8] to the odd lane. A word load output-enables both lanes and returns {odd, even}.
- R5: A byte store writes `req_wdata[7:0]` only to the lane picked by address bit 0 (0 = even lane, 1 = odd lane). Only that lane's write-enable and chip-enable act. The other byte of the word keeps its value.
- R6: A byte load output-enables only the lane picked by address bit 0 and returns that byte in [7:0]. Bits [15:8] are copies of bit 7 when `req_sext` is 1 and zeros when it is 0.
- R7: A write-enable is low only during the second cycle of a store, never for two cycles in a row, and is high again after the edge that ends that cycle. The write lands at that edge.
- R8: `res_valid` is 1 with the load result on `res_data` during the second cycle of a load, and 0 during the second cycle of a store.
- R9: With `busy` 0, `req_op` 5, 6 or 7 with `req_valid` gives, in the same cycle, `res_valid`=1 and `res_data` equal to operand<<8, operand>>8 (logical) or operand>>>8 (arithmetic). No bank enable acts and `busy` stays 0.
- R10: A shift request while `busy` is 1 gives no shift result: `res_valid` follows the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 none, 1 LDW, 2 LDB, 3 STW, 4 STB, 5 LSL8, 6 LSR8, 7 ASR8) |
| req_sext | input | 1 | Byte load: 1 sign-extends, 0 zero-extends |
| req_addr | input | 16 | Byte address computed upstream |
| req_wdata | input | 16 | Store data or shift operand |
| busy | output | 1 | High in the second cycle of a memory access |
| res_valid | output | 1 | Load result or shift result valid on res_data |
| res_data | output | 16 | Load or shift result |
| bank_addr | output | BANK_AW | Word index from the address register |
| lo_ce_n | output | 1 | Even-lane chip enable |
| lo_we_n | output | 1 | Even-lane write enable |
| lo_oe_n | output | 1 | Even-lane output enable |
| hi_ce_n | output | 1 | Odd-lane chip enable |
| hi_we_n | output | 1 | Odd-lane write enable |
| hi_oe_n | output | 1 | Odd-lane output enable |

## Verification
Memory requests are driven on a falling edge and taken at the next rising edge. The enables, `busy` and any load result belong to the cycle after that, so the bench samples them at the following falling edge. One further edge later the strobes must be back high and `busy` low, and the bench samples again at the falling edge after that. Shift results are combinational, so they are sampled one nanosecond after the operands change within the same cycle. Requests injected in the middle of the second cycle check that a busy unit ignores them: a later word load must read back the memory unchanged.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int LANES  = WORD_W / BYTE_W;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LDW  = 3'd1,
    OP_LDB  = 3'd2,
    OP_STW  = 3'd3,
    OP_STB  = 3'd4,
    OP_LSL8 = 3'd5,
    OP_LSR8 = 3'd6,
    OP_ASR8 = 3'd7
  } lsu_op_e;

  typedef struct packed {
    logic load;
    logic store;
    logic byte_acc;
    logic odd;
    logic sext;
  } acc_ctl_t;

  function automatic logic op_is_mem(logic [2:0] op);
    return (op >= OP_LDW) && (op <= OP_STB);
  endfunction

  function automatic logic op_is_shift(logic [2:0] op);
    return op >= OP_LSL8;
  endfunction
endpackage

// File: rtl/lsu_shl8.sv
module lsu_shl8 #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int HALF = W / 2;

  always_comb begin
    dout = {din[HALF-1:0], {HALF{1'b0}}};
  end
endmodule

// File: rtl/lsu_shr8ext.sv
module lsu_shr8ext #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic         shift,
  input  logic         ext_en,
  input  logic         sext,
  output logic [W-1:0] dout
);
  localparam int HALF = W / 2;

  logic [HALF-1:0] pick;
  logic            fill;

  always_comb begin
    pick = shift ? din[W-1:HALF] : din[HALF-1:0];
    fill = sext & pick[HALF-1];
    if (ext_en) dout = {{HALF{fill}}, pick};
    else        dout = din;
  end
endmodule

// File: rtl/lsu_bank.sv
module lsu_bank #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];
  logic          wr_en;

  assign wr_en = ~ce_n & ~we_n;

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= din;
  end

  always_comb begin
    if (!ce_n && !oe_n) dout = cells[addr];
    else                dout = '0;
  end
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int BANK_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic               req_sext,
  input  logic [WORD_W-1:0]  req_addr,
  input  logic [WORD_W-1:0]  st_data,
  output logic               ph2,
  output acc_ctl_t           ctl,
  output logic [BANK_AW-1:0] mar,
  output logic [WORD_W-1:0]  mdr
);
  logic               ph2_q, ph2_d;
  acc_ctl_t           ctl_q, ctl_d;
  logic [BANK_AW-1:0] mar_q, mar_d;
  logic [WORD_W-1:0]  mdr_q, mdr_d;
  logic               accept;

  always_comb begin
    accept = req_valid & ~ph2_q & op_is_mem(req_op);
    ph2_d  = accept;
    ctl_d  = ctl_q;
    mar_d  = mar_q;
    mdr_d  = mdr_q;
    if (accept) begin
      ctl_d.load     = (req_op == OP_LDW) || (req_op == OP_LDB);
      ctl_d.store    = (req_op == OP_STW) || (req_op == OP_STB);
      ctl_d.byte_acc = (req_op == OP_LDB) || (req_op == OP_STB);
      ctl_d.odd      = req_addr[0];
      ctl_d.sext     = req_sext;
      mar_d          = req_addr[BANK_AW:1];
      mdr_d          = st_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph2_q <= 1'b0;
      ctl_q <= '0;
    end else begin
      ph2_q <= ph2_d;
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      mar_q <= mar_d;
      mdr_q <= mdr_d;
    end
  end

  assign ph2 = ph2_q;
  assign ctl = ctl_q;
  assign mar = mar_q;
  assign mdr = mdr_q;
endmodule

// File: rtl/lsu_bytelane.sv
module lsu_bytelane
  import lsu_pkg::*;
#(
  parameter int BANK_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic               req_sext,
  input  logic [15:0]        req_addr,
  input  logic [15:0]        req_wdata,
  output logic               busy,
  output logic               res_valid,
  output logic [15:0]        res_data,
  output logic [BANK_AW-1:0] bank_addr,
  output logic               lo_ce_n,
  output logic               lo_we_n,
  output logic               lo_oe_n,
  output logic               hi_ce_n,
  output logic               hi_we_n,
  output logic               hi_oe_n
);
  logic [1:0]         rst_sync_q;
  logic               rst_q;
  logic               ph2;
  acc_ctl_t           ctl;
  logic [BANK_AW-1:0] mar;
  logic [WORD_W-1:0]  mdr;
  logic [WORD_W-1:0]  shl_out, shr_in, shr_out, st_data, mem_word;
  logic               shr_shift, shr_ext, shr_sext;
  logic [LANES-1:0]   lane_sel, ce_n, we_n, oe_n;
  logic [BYTE_W-1:0]  lane_dout [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  lsu_shl8 #(.W(WORD_W)) shl_i (.din(req_wdata), .dout(shl_out));

  always_comb begin
    st_data = ((req_op == OP_STB) && req_addr[0]) ? shl_out : req_wdata;
  end

  lsu_ctrl #(.BANK_AW(BANK_AW)) ctrl_i (
    .clk(clk), .rst_n(rst_q), .req_valid(req_valid), .req_op(req_op),
    .req_sext(req_sext), .req_addr(req_addr), .st_data(st_data),
    .ph2(ph2), .ctl(ctl), .mar(mar), .mdr(mdr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (g == 0) lane_sel[g] = ~ctl.byte_acc | ~ctl.odd;
      else        lane_sel[g] = ~ctl.byte_acc | ctl.odd;
      ce_n[g] = ~(ph2 & lane_sel[g]);
      we_n[g] = ~(ph2 & lane_sel[g] & ctl.store);
      oe_n[g] = ~(ph2 & lane_sel[g] & ctl.load);
    end

    lsu_bank #(.AW(BANK_AW), .DW(BYTE_W)) bank_i (
      .clk(clk), .ce_n(ce_n[g]), .we_n(we_n[g]), .oe_n(oe_n[g]),
      .addr(mar), .din(mdr[g*BYTE_W +: BYTE_W]), .dout(lane_dout[g])
    );

    assign mem_word[g*BYTE_W +: BYTE_W] = lane_dout[g];
  end

  always_comb begin
    if (ph2) begin
      shr_in    = mem_word;
      shr_shift = ctl.byte_acc & ctl.odd;
      shr_ext   = ctl.byte_acc;
      shr_sext  = ctl.sext;
    end else begin
      shr_in    = req_wdata;
      shr_shift = 1'b1;
      shr_ext   = 1'b1;
      shr_sext  = (req_op == OP_ASR8);
    end
  end

  lsu_shr8ext #(.W(WORD_W)) shr_i (
    .din(shr_in), .shift(shr_shift), .ext_en(shr_ext), .sext(shr_sext),
    .dout(shr_out)
  );

  always_comb begin
    if (!ph2 && (req_op == OP_LSL8)) res_data = shl_out;
    else                             res_data = shr_out;
    if (ph2) res_valid = ctl.load;
    else     res_valid = req_valid & op_is_shift(req_op);
  end

  assign busy      = ph2;
  assign bank_addr = mar;
  assign lo_ce_n   = ce_n[0];
  assign lo_we_n   = we_n[0];
  assign lo_oe_n   = oe_n[0];
  assign hi_ce_n   = ce_n[1];
  assign hi_we_n   = we_n[1];
  assign hi_oe_n   = oe_n[1];
endmodule

// File: rtl/lsu_bytelane_chk.sv
module lsu_bytelane_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       busy,
  input logic       res_valid,
  input logic       lo_ce_n,
  input logic       lo_we_n,
  input logic       lo_oe_n,
  input logic       hi_ce_n,
  input logic       hi_we_n,
  input logic       hi_oe_n
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_op >= 3'd1 && req_op <= 3'd4) |=> busy);

  p_busy_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lo_ce_n && lo_we_n && lo_oe_n && hi_ce_n && hi_we_n && hi_oe_n));

  p_lo_we_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_we_n |=> lo_we_n);

  p_hi_we_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_we_n |=> hi_we_n);

  p_we_with_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((!lo_we_n -> !lo_ce_n) && (!hi_we_n -> !hi_ce_n)));

  p_no_we_and_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !((!lo_we_n || !hi_we_n) && (!lo_oe_n || !hi_oe_n)));

  p_store_no_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_we_n || !hi_we_n) |-> !res_valid);

  p_shift_no_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_op >= 3'd5) |=> !busy);
endmodule

bind lsu_bytelane lsu_bytelane_chk chk_i (
  .clk(clk), .rst_n(rst_q), .req_valid(req_valid), .req_op(req_op),
  .busy(busy), .res_valid(res_valid),
  .lo_ce_n(lo_ce_n), .lo_we_n(lo_we_n), .lo_oe_n(lo_oe_n),
  .hi_ce_n(hi_ce_n), .hi_we_n(hi_we_n), .hi_oe_n(hi_oe_n)
);

// File: tb/lsu_bytelane_tb.sv
`timescale 1ns/1ps
module lsu_bytelane_tb_top;
  localparam int BANK_AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic req_sext = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic busy, res_valid;
  logic [15:0] res_data;
  logic [BANK_AW-1:0] bank_addr;
  logic lo_ce_n, lo_we_n, lo_oe_n, hi_ce_n, hi_we_n, hi_oe_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic p_busy, p_rv, p_lo_we, p_hi_we, p_lo_oe, p_hi_oe, p_lo_ce, p_hi_ce, inj_rv;
  logic [15:0] p_rd;
  logic q_busy, q_lo_we, q_hi_we;

  always #5 clk = ~clk;

  lsu_bytelane #(.BANK_AW(BANK_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_sext(req_sext), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .res_valid(res_valid), .res_data(res_data),
    .bank_addr(bank_addr),
    .lo_ce_n(lo_ce_n), .lo_we_n(lo_we_n), .lo_oe_n(lo_oe_n),
    .hi_ce_n(hi_ce_n), .hi_we_n(hi_we_n), .hi_oe_n(hi_oe_n)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Runs one memory access; optionally injects a request during the second cycle.
  task automatic access(logic [2:0] op, logic [15:0] addr, logic [15:0] wd, logic sx,
                        bit inject, logic [2:0] iop, logic [15:0] iwd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd; req_sext = sx;
    @(negedge clk);
    p_busy = busy; p_rv = res_valid; p_rd = res_data;
    p_lo_we = lo_we_n; p_hi_we = hi_we_n; p_lo_oe = lo_oe_n; p_hi_oe = hi_oe_n;
    p_lo_ce = lo_ce_n; p_hi_ce = hi_ce_n;
    inj_rv = 1'b0;
    if (inject) begin
      req_valid = 1'b1; req_op = iop; req_wdata = iwd; req_addr = addr;
      #1 inj_rv = res_valid;
    end else begin
      req_valid = 1'b0; req_op = 3'd0;
    end
    @(negedge clk);
    req_valid = 1'b0; req_op = 3'd0;
    q_busy = busy; q_lo_we = lo_we_n; q_hi_we = hi_we_n;
  endtask

  task automatic t_reset;
    chk("R1", "busy", {15'd0, busy}, 16'd0);
    chk("R1", "res_valid", {15'd0, res_valid}, 16'd0);
    chk("R1", "enables", {10'd0, lo_ce_n, lo_we_n, lo_oe_n, hi_ce_n, hi_we_n, hi_oe_n}, 16'h003F);
  endtask

  task automatic t_word;
    access(3'd3, 16'h0010, 16'hA5C3, 1'b0, 0, 3'd0, 16'h0);
    chk("R2", "busy in cycle 2", {15'd0, p_busy}, 16'd1);
    chk("R4", "word store we lo,hi", {14'd0, p_lo_we, p_hi_we}, 16'd0);
    chk("R8", "store res_valid", {15'd0, p_rv}, 16'd0);
    chk("R7", "we released lo,hi", {14'd0, q_lo_we, q_hi_we}, 16'd3);
    chk("R2", "busy after", {15'd0, q_busy}, 16'd0);
    access(3'd1, 16'h0011, 16'h0, 1'b0, 0, 3'd0, 16'h0);
    chk("R4", "word load oe lo,hi", {14'd0, p_lo_oe, p_hi_oe}, 16'd0);
    chk("R8", "load res_valid", {15'd0, p_rv}, 16'd1);
    chk("R4", "word load data odd addr", p_rd, 16'hA5C3);
  endtask

  task automatic t_byte_store;
    access(3'd3, 16'h0020, 16'h1111, 1'b0, 0, 3'd0, 16'h0);
    access(3'd4, 16'h0020, 16'h22AB, 1'b0, 0, 3'd0, 16'h0);
    chk("R5", "even byte we lo,hi", {14'd0, p_lo_we, p_hi_we}, 16'd1);
    chk("R5", "even byte ce hi", {15'd0, p_hi_ce}, 16'd1);
    access(3'd4, 16'h0021, 16'h0077, 1'b0, 0, 3'd0, 16'h0);
    chk("R5", "odd byte we lo,hi", {14'd0, p_lo_we, p_hi_we}, 16'd2);
    access(3'd1, 16'h0020, 16'h0, 1'b0, 0, 3'd0, 16'h0);
    chk("R5", "merged word", p_rd, 16'h77AB);
  endtask

  task automatic t_byte_load;
    access(3'd3, 16'h0030, 16'h8F7E, 1'b0, 0, 3'd0, 16'h0);
    access(3'd2, 16'h0031, 16'h0, 1'b1, 0, 3'd0, 16'h0);
    chk("R6", "odd sext", p_rd, 16'hFF8F);
    chk("R6", "odd oe lo,hi", {14'd0, p_lo_oe, p_hi_oe}, 16'd2);
    access(3'd2, 16'h0031, 16'h0, 1'b0, 0, 3'd0, 16'h0);
    chk("R6", "odd zext", p_rd, 16'h008F);
    access(3'd2, 16'h0030, 16'h0, 1'b1, 0, 3'd0, 16'h0);
    chk("R6", "even sext positive", p_rd, 16'h007E);
    chk("R6", "even oe lo,hi", {14'd0, p_lo_oe, p_hi_oe}, 16'd1);
    access(3'd3, 16'h0040, 16'h00F0, 1'b0, 0, 3'd0, 16'h0);
    access(3'd2, 16'h0040, 16'h0, 1'b1, 0, 3'd0, 16'h0);
    chk("R6", "even sext negative", p_rd, 16'hFFF0);
  endtask

  task automatic t_shift(logic [2:0] op, logic [15:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_wdata = a;
    #1;
    chk("R9", {tag, " result"}, res_data, exp);
    chk("R9", {tag, " valid"}, {15'd0, res_valid}, 16'd1);
    @(negedge clk);
    chk("R9", {tag, " no busy/enables"}, {9'd0, busy, lo_ce_n, lo_we_n, lo_oe_n, hi_ce_n, hi_we_n, hi_oe_n}, 16'h003F);
    req_valid = 1'b0; req_op = 3'd0;
  endtask

  task automatic t_busy_ignore;
    access(3'd3, 16'h0050, 16'h1234, 1'b0, 1, 3'd3, 16'hBEEF);
    chk("R3", "no new access", {15'd0, q_busy}, 16'd0);
    access(3'd1, 16'h0050, 16'h0, 1'b0, 0, 3'd0, 16'h0);
    chk("R3", "memory unchanged", p_rd, 16'h1234);
    access(3'd3, 16'h0052, 16'h5678, 1'b0, 1, 3'd5, 16'h00AA);
    chk("R10", "shift during store", {15'd0, inj_rv}, 16'd0);
    access(3'd1, 16'h0052, 16'h0, 1'b0, 1, 3'd6, 16'hFF00);
    chk("R10", "shift during load keeps load", {inj_rv ? p_rd : 16'hDEAD}, 16'h5678);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_word();
    t_byte_store();
    t_byte_load();
    t_shift(3'd5, 16'h12C4, 16'hC400, "lsl8");
    t_shift(3'd6, 16'h8421, 16'h0084, "lsr8");
    t_shift(3'd7, 16'h8421, 16'hFF84, "asr8 neg");
    t_shift(3'd7, 16'h7F00, 16'h007F, "asr8 pos");
    t_busy_ignore();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule